// File: doc/BRIEF.md
# Instruction Step Dispatch Controller

This controller runs the outer loop of a simple processor core, one architectural step at a time. Each step begins with a look at a pending-interrupt input. When an interrupt is pending, the step goes straight to the trap handler. Otherwise the controller asks an external fetch unit for the instruction at the current PC, passes the instruction to an external decoder, and then hands it to an external execute unit. Each of these units is reached through a request/acknowledge pair. A request stays high until the unit acknowledges it.

A step ends in one of several ways, and each way affects the state differently:

- **Interrupt:** the step is not retired and not counted.
- **Fetch fault:** the step is not retired and not counted.
- **Decode fault:** the step is counted as stepped but is not retired.
- **Executed instruction:** the step is stepped, and it is retired only when the execute unit reports retirement.

For trap steps, the trap handler returns the PC at which execution continues. For executed instructions, the next PC is the sequential address (PC+2 for a compressed instruction, PC+4 for a base instruction), unless the execute unit redirects it. At the end of every step the controller updates the PC and the counters. It also pulses a platform tick once every TICK_EVERY steps and stops for good when the host reports that it is done.

Top module: `step_dispatch`

## Requirements
- R1: While in the step-start state with `irq_pending` high and `host_done` low, the controller raises `trap_req` with `trap_kind`=0 and does not raise `fetch_req` in that step. It presents `trap_code`=`irq_code`, `trap_priv`=`irq_priv` and `trap_value`=0. The step changes neither `retired_count` nor `step_count`.
- R2: A fetch acknowledged with `fetch_err`=1 leads to a trap with `trap_kind`=1, `trap_code`=`fetch_err_code`, `trap_value`=`fetch_err_addr` and `trap_priv`=0. No decode is requested, and neither counter changes.
- R3: A decode acknowledged with `dec_ok`=0 leads to a trap with `trap_kind`=2 and `trap_code`=ILLEGAL_CODE. `trap_value` is the instruction zero-extended to XLEN: only bits 15:0 for a compressed instruction, all 32 bits for a base one. A fetched word is compressed when its bits 1:0 are not 2'b11. The step increments `step_count` but not `retired_count`.
- R4: After a successful decode, and with `exe_redirect`=0, the PC after the step is PC+2 for a compressed instruction and PC+4 for a base instruction.
- R5: When the execute unit acknowledges with `exe_redirect`=1, the PC after the step is `exe_target`.
- R6: `retired_count` increments by exactly one in a step that executes with `exe_retired`=1, and stays unchanged in every other step.
- R7: In every trap step, the PC after the step is the `trap_pc` value given with `trap_ack`.
- R8: `step_count` increments by one for each step that reaches a decode result (decode fault or execution), and for no other step.
- R9: `tick` is a one-cycle pulse in the cycle after the commit of every TICK_EVERY-th step since reset. Steps of every outcome count toward it.
- R10: If `host_done` is high at a step's commit, the step's PC and counter updates still take effect, no tick is raised, and `halted` goes high and stays high. If `host_done` is high at step start, the controller halts without issuing any request. In both cases `exit_ok` is 1 exactly when `exit_code` was zero when the halt was taken, and no further request is made.
- R11: At most one of `fetch_req`, `dec_req`, `exe_req` and `trap_req` is high at a time. A request stays high until its acknowledge arrives. `fetch_pc` equals the current PC, and `dec_insn` equals the fetched word.
- R12: After reset, `pc`=RESET_PC, both counters are 0, and `tick`, `halted` and `exit_ok` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pending | input | 1 | An enabled interrupt is pending |
| irq_code | input | CODE_W | Cause code of the pending interrupt |
| irq_priv | input | 2 | Target privilege of the pending interrupt |
| fetch_req | output | 1 | Fetch request |
| fetch_pc | output | XLEN | Address to fetch |
| fetch_ack | input | 1 | Fetch done |
| fetch_err | input | 1 | Fetch faulted |
| fetch_err_code | input | CODE_W | Fault cause code |
| fetch_err_addr | input | XLEN | Faulting address |
| fetch_insn | input | 32 | Fetched instruction word |
| fetch_compressed | input | 1 | Fetched word is a 16-bit instruction |
| dec_req | output | 1 | Decode request |
| dec_insn | output | 32 | Word to decode |
| dec_compressed | output | 1 | Word is a 16-bit instruction |
| dec_ack | input | 1 | Decode done |
| dec_ok | input | 1 | Decode succeeded |
| exe_req | output | 1 | Execute request |
| exe_ack | input | 1 | Execute done |
| exe_retired | input | 1 | Instruction retired |
| exe_redirect | input | 1 | Execute changed the next PC |
| exe_target | input | XLEN | Redirected next PC |
| trap_req | output | 1 | Trap handler request |
| trap_kind | output | 2 | 0 interrupt, 1 fetch fault, 2 illegal instruction |
| trap_code | output | CODE_W | Trap cause code |
| trap_value | output | XLEN | Trap value |
| trap_priv | output | 2 | Target privilege (interrupt only, else 0) |
| trap_ack | input | 1 | Trap handled |
| trap_pc | input | XLEN | PC to resume at |
| host_done | input | 1 | Host requests stop |
| exit_code | input | EXIT_W | Host exit code |
| pc | output | XLEN | Current PC |
| retired_count | output | CNT_W | Retired instructions |
| step_count | output | CNT_W | Stepped steps |
| tick | output | 1 | Platform tick pulse |
| halted | output | 1 | Loop stopped |
| exit_ok | output | 1 | Exit code was zero at halt |

## Verification
The tick and the halt both come out of the same commit cycle. The bench therefore holds `host_done` high over the commit of a step whose position in the count would otherwise raise the tick. It then expects the PC and counters of that step to update, `tick` to stay low, and `halted` to rise. Interrupt start is also pitted against a fetch that could begin in the same cycle: an interrupt raised at step start must produce a trap with no fetch request at all. A decode fault must split the stepped and retired counters by one.

// File: rtl/step_dispatch.sv
module step_dispatch #(
  parameter int XLEN = 32,
  parameter int CODE_W = 5,
  parameter int CNT_W = 32,
  parameter int EXIT_W = 8,
  parameter int TICK_EVERY = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  parameter logic [CODE_W-1:0] ILLEGAL_CODE = CODE_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pending,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [1:0]        irq_priv,
  output logic              fetch_req,
  output logic [XLEN-1:0]   fetch_pc,
  input  logic              fetch_ack,
  input  logic              fetch_err,
  input  logic [CODE_W-1:0] fetch_err_code,
  input  logic [XLEN-1:0]   fetch_err_addr,
  input  logic [31:0]       fetch_insn,
  input  logic              fetch_compressed,
  output logic              dec_req,
  output logic [31:0]       dec_insn,
  output logic              dec_compressed,
  input  logic              dec_ack,
  input  logic              dec_ok,
  output logic              exe_req,
  input  logic              exe_ack,
  input  logic              exe_retired,
  input  logic              exe_redirect,
  input  logic [XLEN-1:0]   exe_target,
  output logic              trap_req,
  output logic [1:0]        trap_kind,
  output logic [CODE_W-1:0] trap_code,
  output logic [XLEN-1:0]   trap_value,
  output logic [1:0]        trap_priv,
  input  logic              trap_ack,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              host_done,
  input  logic [EXIT_W-1:0] exit_code,
  output logic [XLEN-1:0]   pc,
  output logic [CNT_W-1:0]  retired_count,
  output logic [CNT_W-1:0]  step_count,
  output logic              tick,
  output logic              halted,
  output logic              exit_ok
);
  localparam int TCW = (TICK_EVERY > 1) ? $clog2(TICK_EVERY) : 1;
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TICK_EVERY - 1);
  localparam logic [1:0] K_IRQ = 2'd0;
  localparam logic [1:0] K_FETCH = 2'd1;
  localparam logic [1:0] K_ILLEGAL = 2'd2;

  typedef enum logic [2:0] {
    S_START, S_FETCH, S_DEC, S_EXE, S_TRAP, S_COMMIT, S_HALT
  } state_t;

  state_t            state;
  logic [XLEN-1:0]   pc_q, npc_q;
  logic [31:0]       insn_q;
  logic              comp_q;
  logic              stepped_q, retired_q;
  logic [1:0]        kind_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   tval_q;
  logic [1:0]        priv_q;
  logic [CNT_W-1:0]  ret_q, step_q;
  logic [TCW-1:0]    tcnt_q;
  logic              tick_q, exit_ok_q;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] illegal_val;
  logic            tick_due;

  assign seq_pc      = pc_q + (comp_q ? XLEN'(2) : XLEN'(4));
  assign illegal_val = comp_q ? XLEN'(insn_q[15:0]) : XLEN'(insn_q);
  assign tick_due    = (tcnt_q == TICK_LAST);

  assign fetch_req      = (state == S_FETCH);
  assign dec_req        = (state == S_DEC);
  assign exe_req        = (state == S_EXE);
  assign trap_req       = (state == S_TRAP);
  assign fetch_pc       = pc_q;
  assign dec_insn       = insn_q;
  assign dec_compressed = comp_q;
  assign trap_kind      = kind_q;
  assign trap_code      = code_q;
  assign trap_value     = tval_q;
  assign trap_priv      = priv_q;
  assign pc             = pc_q;
  assign retired_count  = ret_q;
  assign step_count     = step_q;
  assign tick           = tick_q;
  assign halted         = (state == S_HALT);
  assign exit_ok        = exit_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_START;
      pc_q      <= RESET_PC;
      npc_q     <= RESET_PC;
      insn_q    <= '0;
      comp_q    <= 1'b0;
      stepped_q <= 1'b0;
      retired_q <= 1'b0;
      kind_q    <= K_IRQ;
      code_q    <= '0;
      tval_q    <= '0;
      priv_q    <= '0;
      ret_q     <= '0;
      step_q    <= '0;
      tcnt_q    <= '0;
      tick_q    <= 1'b0;
      exit_ok_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      unique case (state)
        S_START: begin
          stepped_q <= 1'b0;
          retired_q <= 1'b0;
          if (host_done) begin
            exit_ok_q <= (exit_code == '0);
            state     <= S_HALT;
          end else if (irq_pending) begin
            kind_q <= K_IRQ;
            code_q <= irq_code;
            tval_q <= '0;
            priv_q <= irq_priv;
            state  <= S_TRAP;
          end else begin
            state <= S_FETCH;
          end
        end
        S_FETCH: if (fetch_ack) begin
          if (fetch_err) begin
            kind_q <= K_FETCH;
            code_q <= fetch_err_code;
            tval_q <= fetch_err_addr;
            priv_q <= '0;
            state  <= S_TRAP;
          end else begin
            insn_q <= fetch_insn;
            comp_q <= fetch_compressed;
            state  <= S_DEC;
          end
        end
        S_DEC: if (dec_ack) begin
          stepped_q <= 1'b1;
          if (dec_ok) begin
            npc_q <= seq_pc;
            state <= S_EXE;
          end else begin
            kind_q <= K_ILLEGAL;
            code_q <= ILLEGAL_CODE;
            tval_q <= illegal_val;
            priv_q <= '0;
            state  <= S_TRAP;
          end
        end
        S_EXE: if (exe_ack) begin
          retired_q <= exe_retired;
          if (exe_redirect) npc_q <= exe_target;
          state <= S_COMMIT;
        end
        S_TRAP: if (trap_ack) begin
          npc_q <= trap_pc;
          state <= S_COMMIT;
        end
        S_COMMIT: begin
          pc_q <= npc_q;
          if (retired_q) ret_q <= ret_q + 1'b1;
          if (stepped_q) step_q <= step_q + 1'b1;
          if (host_done) begin
            exit_ok_q <= (exit_code == '0);
            state     <= S_HALT;
          end else begin
            tick_q <= tick_due;
            tcnt_q <= tick_due ? '0 : tcnt_q + 1'b1;
            state  <= S_START;
          end
        end
        S_HALT: state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end
endmodule

module step_dispatch_chk #(
  parameter int XLEN = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_req,
  input logic             fetch_ack,
  input logic             dec_req,
  input logic             dec_ack,
  input logic             exe_req,
  input logic             exe_ack,
  input logic             trap_req,
  input logic             trap_ack,
  input logic [XLEN-1:0]  pc,
  input logic [CNT_W-1:0] retired_count,
  input logic [CNT_W-1:0] step_count,
  input logic             tick,
  input logic             halted
);
  a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, dec_req, exe_req, trap_req}));

  a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack) |=> fetch_req);

  a_r11_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_ack) |=> trap_req);

  a_r11_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !dec_ack) |=> dec_req);

  a_r11_exe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_req && !exe_ack) |=> exe_req);

  a_r6_retire_unit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(retired_count) |-> retired_count == $past(retired_count) + 1'b1);

  a_r8_step_unit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step_count) |-> step_count == $past(step_count) + 1'b1);

  a_r6_retire_le_step: assert property (@(posedge clk) disable iff (!rst_n)
    retired_count <= step_count);

  a_r9_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !fetch_req && !trap_req && !tick && $stable(pc));
endmodule

bind step_dispatch step_dispatch_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .fetch_req(fetch_req), .fetch_ack(fetch_ack),
  .dec_req(dec_req), .dec_ack(dec_ack),
  .exe_req(exe_req), .exe_ack(exe_ack),
  .trap_req(trap_req), .trap_ack(trap_ack),
  .pc(pc), .retired_count(retired_count), .step_count(step_count),
  .tick(tick), .halted(halted)
);

// File: tb/step_dispatch_tb.sv
module step_dispatch_tb;
  localparam int XLEN = 32;
  localparam int CODE_W = 5;
  localparam int CNT_W = 16;
  localparam int EXIT_W = 8;
  localparam int TICK_EVERY = 3;
  localparam logic [XLEN-1:0] RESET_PC = 32'h0000_0100;
  localparam logic [CODE_W-1:0] ILLEGAL_CODE = 5'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_pending = 0;
  logic [CODE_W-1:0] irq_code = 5'd7;
  logic [1:0] irq_priv = 2'd3;
  logic fetch_req, dec_req, exe_req, trap_req;
  logic [XLEN-1:0] fetch_pc;
  logic fetch_ack = 0, fetch_err = 0, fetch_compressed = 0;
  logic [CODE_W-1:0] fetch_err_code = 5'd1;
  logic [XLEN-1:0] fetch_err_addr = '0;
  logic [31:0] fetch_insn = '0;
  logic [31:0] dec_insn;
  logic dec_compressed;
  logic dec_ack = 0, dec_ok = 0;
  logic exe_ack = 0, exe_retired = 0, exe_redirect = 0;
  logic [XLEN-1:0] exe_target = '0;
  logic [1:0] trap_kind, trap_priv;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0] trap_value;
  logic trap_ack = 0;
  logic [XLEN-1:0] trap_pc = '0;
  logic host_done = 0;
  logic [EXIT_W-1:0] exit_code = '0;
  logic [XLEN-1:0] pc;
  logic [CNT_W-1:0] retired_count, step_count;
  logic tick, halted, exit_ok;

  always #4 clk = ~clk;

  step_dispatch #(
    .XLEN(XLEN), .CODE_W(CODE_W), .CNT_W(CNT_W), .EXIT_W(EXIT_W),
    .TICK_EVERY(TICK_EVERY), .RESET_PC(RESET_PC), .ILLEGAL_CODE(ILLEGAL_CODE)
  ) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int ticks_seen = 0;
  int ticks_exp = 0;

  logic [XLEN-1:0] m_pc;
  int m_ret, m_step, m_iter;

  always @(negedge clk) if (rst_n && tick) ticks_seen++;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic clear_acks();
    fetch_ack = 0; dec_ack = 0; exe_ack = 0; trap_ack = 0;
  endtask

  task automatic do_reset(input bit done_level, input logic [EXIT_W-1:0] code);
    rst_n = 0;
    host_done = done_level;
    exit_code = code;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_pc = RESET_PC; m_ret = 0; m_step = 0; m_iter = 0;
    check("R12 pc", pc, RESET_PC);
    check("R12 retired", retired_count, 0);
    check("R12 steps", step_count, 0);
    check("R12 tick/halted/exit_ok", {tick, halted, exit_ok}, 0);
  endtask

  // kind: 0 irq, 1 fetch fault, 2 decode fault, 3 exec retire, 4 exec no retire, 5 exec redirect+retire
  task automatic run_step(input int kind, input logic [31:0] word, input bit done_now);
    logic [XLEN-1:0] npc, tgt;
    logic [1:0] xkind;
    logic [XLEN-1:0] xval;
    logic [CODE_W-1:0] xcode;
    logic [1:0] xpriv;
    bit comp, fin, exp_tick;
    comp = (word[1:0] != 2'b11);
    tgt = 32'h0000_8000 + XLEN'(m_iter * 16);
    npc = m_pc;
    irq_pending = (kind == 0);
    fin = 0;
    while (!fin) begin
      @(negedge clk);
      clear_acks();
      if (trap_req) begin
        xkind = (kind == 0) ? 2'd0 : (kind == 1) ? 2'd1 : 2'd2;
        xcode = (kind == 0) ? irq_code : (kind == 1) ? fetch_err_code : ILLEGAL_CODE;
        xval  = (kind == 0) ? '0 : (kind == 1) ? m_pc + 32'd2
                : (comp ? {16'h0, word[15:0]} : word);
        xpriv = (kind == 0) ? irq_priv : 2'd0;
        if (kind == 0) check("R1 trap kind", trap_kind, xkind);
        else if (kind == 1) check("R2 trap kind", trap_kind, xkind);
        else check("R3 trap kind", trap_kind, xkind);
        check((kind == 0) ? "R1 trap code" : (kind == 1) ? "R2 trap code" : "R3 trap code",
              trap_code, xcode);
        check((kind == 0) ? "R1 trap value" : (kind == 1) ? "R2 trap value" : "R3 trap value",
              trap_value, xval);
        check((kind == 0) ? "R1 trap priv" : "R2 trap priv", trap_priv, xpriv);
        trap_pc = tgt;
        trap_ack = 1;
        npc = tgt;
        fin = 1;
      end else if (fetch_req) begin
        if (kind == 0) check("R1 fetch while interrupt pending", 1, 0);
        check("R11 fetch pc", fetch_pc, m_pc);
        fetch_err = (kind == 1);
        fetch_err_addr = m_pc + 32'd2;
        fetch_insn = word;
        fetch_compressed = comp;
        fetch_ack = 1;
      end else if (dec_req) begin
        if (kind < 2) check("R2 decode after fault", 1, 0);
        check("R11 decode word", dec_insn, word);
        dec_ok = (kind >= 3);
        dec_ack = 1;
      end else if (exe_req) begin
        exe_retired = (kind == 3 || kind == 5);
        exe_redirect = (kind == 5);
        exe_target = tgt + 32'h40;
        exe_ack = 1;
        npc = (kind == 5) ? tgt + 32'h40 : m_pc + (comp ? 32'd2 : 32'd4);
        fin = 1;
      end
    end
    @(negedge clk);
    clear_acks();
    irq_pending = 0;
    if (done_now) host_done = 1;
    @(negedge clk);
    m_pc = npc;
    if (kind >= 2) m_step++;
    if (kind == 3 || kind == 5) m_ret++;
    exp_tick = 0;
    if (!done_now) begin
      exp_tick = ((m_iter % TICK_EVERY) == TICK_EVERY - 1);
      m_iter++;
    end
    if (exp_tick) ticks_exp++;
    case (kind)
      0, 1, 2: check("R7 trap resume pc", pc, m_pc);
      5: check("R5 redirect pc", pc, m_pc);
      default: check("R4 sequential pc", pc, m_pc);
    endcase
    check("R6 retired count", retired_count, m_ret);
    check("R8 step count", step_count, m_step);
    check(done_now ? "R10 no tick at halt" : "R9 tick", tick, exp_tick);
    check("R10 halted", halted, done_now);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] words[4];
    words[0] = 32'hDEAD_4501;
    words[1] = 32'h00A0_0513;
    words[2] = 32'hBEEF_8082;
    words[3] = 32'hFFFF_FFFF;
    do_reset(0, 8'd0);
    for (int rep = 0; rep < 2; rep++)
      for (int k = 0; k < 6; k++)
        for (int w = 0; w < 4; w++)
          run_step(k, words[w], 0);
    // reach a step whose commit would tick, then stop on it
    while ((m_iter % TICK_EVERY) != TICK_EVERY - 1) run_step(3, words[1], 0);
    run_step(3, words[0], 1);
    check("R10 exit_ok zero code", exit_ok, 1);
    check("R9 tick total", ticks_seen, ticks_exp);
    repeat (4) @(negedge clk);
    check("R10 stays halted", {halted, fetch_req, trap_req}, 3'b100);
    // host done before any step, nonzero exit code
    do_reset(1, 8'd5);
    @(negedge clk);
    check("R10 halt at step start", halted, 1);
    check("R10 exit_ok nonzero code", exit_ok, 0);
    repeat (3) @(negedge clk);
    check("R10 no request when halted", {fetch_req, trap_req, pc}, {2'b00, RESET_PC});
    finish_run();
  end
endmodule